// File: doc/BRIEF.md
# Interleaved DRAM Target Decoder

This block turns a physical address into the number of the socket or package that owns it. A bank of programmable rules splits the address space into regions. Each rule has an upper bound given in 64 MB blocks, an enable bit, a two-bit attribute and an index-mode bit. Each rule also has its own table of eight four-bit target entries. For an incoming address the block finds the lowest-numbered enabled rule whose bound covers the address. It then forms a three-bit index from address bits and returns the table entry at that index. The default index is the XOR of a cacheline-level bit group and a group ten bits higher. This spreads consecutive cachelines, and repeated strides, over the targets.

Configuration is a plain write port that writes one rule word or one table word per cycle. A write lands at the clock edge, so a lookup accepted in the next cycle already sees it. Lookups use a valid/ready stream. A request is taken when `req_valid` and `req_ready` are both high. Its result is presented one cycle later and stays unchanged while `res_valid` is high and `res_ready` is low. `req_ready` is high whenever the output slot is empty or is being emptied in the same cycle. This sustains one lookup per cycle when the consumer does not stall.

Top module: `dram_target_decoder`

## Requirements
- R1: There are ten rules. A rule whose enable bit is clear never matches, and a lookup then resolves to another rule or to a miss.
- R2: Rule r covers an address when the address bits [45:26] (its 64 MB block number) are less than or equal to the rule's limit. Address bits [25:0] play no part in the comparison.
- R3: When several enabled rules cover an address, the lowest-numbered one is reported, and its number is given on `res_rule`.
- R4: In index mode 0 the table index is address[8:6] XOR address[18:16].
- R5: In index mode 1 the table index is address[8:6] alone.
- R6: A table word (`cfg_kind`=1) holds entry k in bits [4k+3:4k], for k from 0 to 7. `res_target` is the entry that the index selects.
- R7: A rule word (`cfg_kind`=0) has the enable in bit 0, the attribute in bits [2:1] (0 means DRAM, and the value is reported on `res_attr`), the index mode in bit 3 and the limit in bits [23:4]. Writes with `cfg_idx` of 10 or more are dropped.
- R8: When no enabled rule covers the address, the result has `res_hit`=0 and `res_target`, `res_rule` and `res_attr` all zero.
- R9: A configuration write in one cycle is visible to a lookup accepted in the next cycle.
- R10: A result appears one cycle after its request is accepted, and back-to-back requests are accepted every cycle while `res_ready` is high.
- R11: While `res_valid` is high and `res_ready` is low, all result fields hold steady, and `req_ready` equals `!res_valid || res_ready`.
- R12: After reset all rules are disabled, `res_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 1 | 0 selects a rule word, 1 selects a table word |
| cfg_idx | input | 4 | Rule number being written |
| cfg_wdata | input | 32 | Configuration data |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be taken |
| req_addr | input | 46 | Physical address to decode |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_hit | output | 1 | An enabled rule covered the address |
| res_rule | output | 4 | Number of the matching rule |
| res_target | output | 4 | Selected target entry |
| res_attr | output | 2 | Attribute of the matching rule |

## Verification
The hardest case to reach is a result stalled by the consumer while a request waits and a configuration write rewrites the very rule that produced the held result. The held fields must not move, and the waiting request must decode with the new setting. The stimulus gets there by dropping `res_ready` about a quarter of the time while writing random rule and table words into the request stream. The reference model is updated in the cycle of acceptance, so any leak of a later write into a held result, or of a stale one into a new lookup, shows up as a mismatch. Directed lookups on both sides of a limit block, and on disabled and overlapping rules, cover the priority and bound edges.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;
  // bit positions inside a rule configuration word
  localparam int RW_EN   = 0;
  localparam int RW_ATTR = 1;
  localparam int ATTR_W  = 2;
  localparam int RW_MODE = 3;
  localparam int RW_LIM  = 4;

  localparam logic [ATTR_W-1:0] ATTR_DRAM = 2'd0;

  typedef enum logic {
    IDX_HASHED = 1'b0,
    IDX_LINE   = 1'b1
  } idx_mode_e;

  typedef enum logic {
    CFG_RULE = 1'b0,
    CFG_LIST = 1'b1
  } cfg_kind_e;
endpackage

// File: rtl/dram_rule_bank.sv
module dram_rule_bank
  import dram_dec_pkg::*;
#(
  parameter int NUM_RULES = 10,
  parameter int LIMIT_W   = 20,
  parameter int LIST_N    = 8,
  parameter int TGT_W     = 4,
  parameter int CFG_W     = 32,
  parameter int IDX_W     = 4
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     cfg_we,
  input  logic                                     cfg_kind,
  input  logic [IDX_W-1:0]                         cfg_idx,
  input  logic [CFG_W-1:0]                         cfg_wdata,
  output logic [NUM_RULES-1:0]                     rule_en,
  output logic [NUM_RULES-1:0]                     rule_mode,
  output logic [NUM_RULES-1:0][ATTR_W-1:0]         rule_attr,
  output logic [NUM_RULES-1:0][LIMIT_W-1:0]        rule_lim,
  output logic [NUM_RULES-1:0][LIST_N-1:0][TGT_W-1:0] rule_list
);
  localparam int LIST_BITS = LIST_N * TGT_W;

  for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
    logic sel_rule;
    logic sel_list;
    assign sel_rule = cfg_we && (cfg_kind == CFG_RULE) && (cfg_idx == IDX_W'(g));
    assign sel_list = cfg_we && (cfg_kind == CFG_LIST) && (cfg_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rule_en[g]   <= 1'b0;
        rule_mode[g] <= 1'b0;
        rule_attr[g] <= '0;
        rule_lim[g]  <= '0;
        rule_list[g] <= '0;
      end else begin
        if (sel_rule) begin
          rule_en[g]   <= cfg_wdata[RW_EN];
          rule_attr[g] <= cfg_wdata[RW_ATTR +: ATTR_W];
          rule_mode[g] <= cfg_wdata[RW_MODE];
          rule_lim[g]  <= cfg_wdata[RW_LIM +: LIMIT_W];
        end
        if (sel_list) begin
          rule_list[g] <= cfg_wdata[LIST_BITS-1:0];
        end
      end
    end
  end

  // R7: a rule write to a valid index lands in that rule's enable
  p_rule_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_kind == CFG_RULE && cfg_idx < IDX_W'(NUM_RULES))
      |=> rule_en[$past(cfg_idx)] == $past(cfg_wdata[RW_EN]));

  // R12: reset leaves every rule disabled
  p_reset_disables_r12: assert property (@(posedge clk)
    $past(!rst_n) |-> rule_en == '0);
endmodule

// File: rtl/dram_rule_match.sv
module dram_rule_match
  import dram_dec_pkg::*;
#(
  parameter int NUM_RULES = 10,
  parameter int ADDR_W    = 46,
  parameter int GRAN_LSB  = 26,
  parameter int LINE_LSB  = 6,
  parameter int HI_LSB    = 16,
  parameter int LIST_N    = 8,
  parameter int TGT_W     = 4,
  parameter int IDX_W     = 4
) (
  input  logic [ADDR_W-1:0]                            addr,
  input  logic [NUM_RULES-1:0]                         rule_en,
  input  logic [NUM_RULES-1:0]                         rule_mode,
  input  logic [NUM_RULES-1:0][ATTR_W-1:0]             rule_attr,
  input  logic [NUM_RULES-1:0][ADDR_W-GRAN_LSB-1:0]    rule_lim,
  input  logic [NUM_RULES-1:0][LIST_N-1:0][TGT_W-1:0]  rule_list,
  output logic                                         hit,
  output logic [IDX_W-1:0]                             rule,
  output logic [TGT_W-1:0]                             target,
  output logic [ATTR_W-1:0]                            attr
);
  localparam int LIMIT_W = ADDR_W - GRAN_LSB;
  localparam int SEL_W   = $clog2(LIST_N);

  logic [LIMIT_W-1:0]   blk;
  logic [NUM_RULES-1:0] in_range;
  logic [SEL_W-1:0]     sel;
  logic                 unused_addr;

  assign blk         = addr[ADDR_W-1:GRAN_LSB];
  assign unused_addr = ^addr;

  for (genvar g = 0; g < NUM_RULES; g++) begin : g_cmp
    assign in_range[g] = rule_en[g] && (blk <= rule_lim[g]);
  end

  // lowest-numbered covering rule wins
  always_comb begin
    hit  = 1'b0;
    rule = '0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (in_range[i]) begin
        hit  = 1'b1;
        rule = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (rule_mode[rule] == IDX_LINE)
      sel = addr[LINE_LSB +: SEL_W];
    else
      sel = addr[LINE_LSB +: SEL_W] ^ addr[HI_LSB +: SEL_W];
  end

  assign target = hit ? rule_list[rule][sel] : '0;
  assign attr   = hit ? rule_attr[rule] : '0;
endmodule

// File: rtl/dram_target_decoder.sv
module dram_target_decoder
  import dram_dec_pkg::*;
#(
  parameter int NUM_RULES = 10,
  parameter int ADDR_W    = 46,
  parameter int GRAN_LSB  = 26,
  parameter int LINE_LSB  = 6,
  parameter int HI_LSB    = 16,
  parameter int LIST_N    = 8,
  parameter int TGT_W     = 4,
  parameter int CFG_W     = 32,
  parameter int IDX_W     = $clog2(NUM_RULES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_kind,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_hit,
  output logic [IDX_W-1:0]  res_rule,
  output logic [TGT_W-1:0]  res_target,
  output logic [ATTR_W-1:0] res_attr
);
  localparam int LIMIT_W = ADDR_W - GRAN_LSB;

  logic [NUM_RULES-1:0]                         rule_en;
  logic [NUM_RULES-1:0]                         rule_mode;
  logic [NUM_RULES-1:0][ATTR_W-1:0]             rule_attr;
  logic [NUM_RULES-1:0][LIMIT_W-1:0]            rule_lim;
  logic [NUM_RULES-1:0][LIST_N-1:0][TGT_W-1:0]  rule_list;

  logic              hit_c;
  logic [IDX_W-1:0]  rule_c;
  logic [TGT_W-1:0]  target_c;
  logic [ATTR_W-1:0] attr_c;
  logic              take;

  dram_rule_bank #(
    .NUM_RULES(NUM_RULES), .LIMIT_W(LIMIT_W), .LIST_N(LIST_N),
    .TGT_W(TGT_W), .CFG_W(CFG_W), .IDX_W(IDX_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .rule_en(rule_en), .rule_mode(rule_mode), .rule_attr(rule_attr),
    .rule_lim(rule_lim), .rule_list(rule_list)
  );

  dram_rule_match #(
    .NUM_RULES(NUM_RULES), .ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB),
    .LINE_LSB(LINE_LSB), .HI_LSB(HI_LSB), .LIST_N(LIST_N),
    .TGT_W(TGT_W), .IDX_W(IDX_W)
  ) u_match (
    .addr(req_addr),
    .rule_en(rule_en), .rule_mode(rule_mode), .rule_attr(rule_attr),
    .rule_lim(rule_lim), .rule_list(rule_list),
    .hit(hit_c), .rule(rule_c), .target(target_c), .attr(attr_c)
  );

  assign req_ready = !res_valid || res_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_rule   <= '0;
      res_target <= '0;
      res_attr   <= '0;
    end else if (take) begin
      res_valid  <= 1'b1;
      res_hit    <= hit_c;
      res_rule   <= rule_c;
      res_target <= target_c;
      res_attr   <= attr_c;
    end else if (res_ready) begin
      res_valid  <= 1'b0;
    end
  end

  // R10: an accepted request is answered in the following cycle
  p_accept_answers_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> res_valid);

  // R11: a stalled result keeps every field
  p_stall_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_hit) && $stable(res_rule)
                                   && $stable(res_target) && $stable(res_attr)));

  // R8: a miss carries all-zero fields
  p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_target == '0 && res_rule == '0 && res_attr == '0));

  // R1: the matcher only ever reports an enabled rule
  p_match_enabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hit_c |-> rule_en[rule_c]);

  // R2: the reported rule's limit covers the address block
  p_match_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_c |-> (req_addr[ADDR_W-1:GRAN_LSB] <= rule_lim[rule_c]));
endmodule

// File: tb/dram_target_decoder_bench.sv
`timescale 1ns/1ps
module dram_target_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_kind = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [45:0] req_addr = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic        res_hit;
  logic [3:0]  res_rule;
  logic [3:0]  res_target;
  logic [1:0]  res_attr;

  always #2 clk = ~clk;

  dram_target_decoder u_dram_target_decoder (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_hit(res_hit), .res_rule(res_rule), .res_target(res_target), .res_attr(res_attr)
  );

  int checks = 0;
  int fails  = 0;

  // reference configuration
  logic        m_en   [10];
  logic        m_mode [10];
  logic [1:0]  m_attr [10];
  logic [19:0] m_lim  [10];
  logic [3:0]  m_list [10][8];

  logic [10:0] exp_q [$];
  string       tag_q [$];
  string       cur_tag = "R10";
  logic        acc_prev = 1'b0;
  logic        stall_prev = 1'b0;
  logic [10:0] held = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // result packing: {hit, rule[3:0], target[3:0], attr[1:0]}
  function automatic logic [10:0] model(input logic [45:0] a);
    logic [19:0] b;
    logic [2:0]  ix;
    b = a[45:26];
    for (int r = 0; r < 10; r++) begin
      if (m_en[r] && b <= m_lim[r]) begin
        ix = m_mode[r] ? a[8:6] : (a[8:6] ^ a[18:16]);
        return {1'b1, 4'(r), m_list[r][ix], m_attr[r]};
      end
    end
    return 11'd0;
  endfunction

  function automatic logic [45:0] mk_addr(input logic [19:0] blk, input logic [25:0] low);
    return {blk, low};
  endfunction

  // one cycle: evaluate what the coming edge does, then wait for the next negedge
  task automatic tick();
    logic [10:0] now;
    logic [10:0] e;
    string t;
    #1;
    now = {res_hit, res_rule, res_target, res_attr};
    if (stall_prev) begin
      chk(res_valid == 1'b1, "R11", "valid held under stall", 32'(res_valid), 32'd1);
      chk(now == held, "R11", "fields held under stall", 32'(now), 32'(held));
    end
    if (acc_prev)
      chk(res_valid == 1'b1, "R10", "result one cycle after accept", 32'(res_valid), 32'd1);
    chk(req_ready == (!res_valid || res_ready), "R11", "req_ready rule",
        32'(req_ready), 32'(!res_valid || res_ready));
    if (res_valid && res_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10", "unexpected result", 32'(now), 32'd0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(now == e, t, "result {hit,rule,target,attr}", 32'(now), 32'(e));
      end
    end
    stall_prev = res_valid && !res_ready;
    held = now;
    acc_prev = req_valid && req_ready;
    if (acc_prev) begin
      exp_q.push_back(model(req_addr));
      tag_q.push_back(cur_tag);
    end
    if (cfg_we && cfg_idx < 4'd10) begin
      if (cfg_kind) begin
        for (int k = 0; k < 8; k++) m_list[cfg_idx][k] = cfg_wdata[4*k +: 4];
      end else begin
        m_en[cfg_idx]   = cfg_wdata[0];
        m_attr[cfg_idx] = cfg_wdata[2:1];
        m_mode[cfg_idx] = cfg_wdata[3];
        m_lim[cfg_idx]  = cfg_wdata[23:4];
      end
    end
    @(negedge clk);
  endtask

  task automatic wr_rule(input int r, input logic en, input logic [1:0] at,
                         input logic md, input logic [19:0] lim);
    cfg_we = 1'b1; cfg_kind = 1'b0; cfg_idx = 4'(r);
    cfg_wdata = {8'h00, lim, md, at, en};
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic wr_list(input int r, input logic [31:0] w);
    cfg_we = 1'b1; cfg_kind = 1'b1; cfg_idx = 4'(r); cfg_wdata = w;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic look(input logic [45:0] a, input string tag);
    req_valid = 1'b1; req_addr = a; cur_tag = tag; res_ready = 1'b1;
    tick();
    req_valid = 1'b0;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int seed_val;
    seed_val = $urandom(32'd2024);
    for (int r = 0; r < 10; r++) begin
      m_en[r] = 1'b0; m_mode[r] = 1'b0; m_attr[r] = 2'd0; m_lim[r] = '0;
      for (int k = 0; k < 8; k++) m_list[r][k] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12: reset state
    #1;
    chk(res_valid == 1'b0, "R12", "res_valid after reset", 32'(res_valid), 32'd0);
    chk(req_ready == 1'b1, "R12", "req_ready after reset", 32'(req_ready), 32'd1);
    @(negedge clk);
    look(mk_addr(20'd0, 26'h0), "R12");

    // two regions: up to 32 GB and up to 64 GB
    wr_rule(0, 1'b1, 2'd0, 1'b0, 20'd511);
    wr_list(0, 32'h76543210);
    wr_rule(1, 1'b1, 2'd0, 1'b0, 20'd1023);
    wr_list(1, 32'hFEDCBA98);

    look(mk_addr(20'd511, 26'h3FFFFFF), "R2");
    look(mk_addr(20'd512, 26'h0), "R2");
    look(mk_addr(20'd1024, 26'h0), "R8");
    // [8:6]=5, [18:16]=3 -> hashed index 6
    look(mk_addr(20'd0, 26'h0030140), "R4");
    look(mk_addr(20'd600, 26'h0070000), "R6");

    // R5 and R9: switch mode, look up in the very next cycle
    wr_rule(0, 1'b1, 2'd0, 1'b1, 20'd511);
    look(mk_addr(20'd0, 26'h0030140), "R5");
    look(mk_addr(20'd0, 26'h0030140), "R9");

    // R1: disabled rule 0 passes the low region to rule 1
    wr_rule(0, 1'b0, 2'd0, 1'b0, 20'd511);
    look(mk_addr(20'd5, 26'h0000040), "R1");

    // R3: overlapping rule 2 loses to rule 1
    wr_rule(2, 1'b1, 2'd1, 1'b0, 20'd100);
    wr_list(2, 32'h11111111);
    look(mk_addr(20'd50, 26'h0), "R3");

    // R7: catch-all rule with non-DRAM attribute, and a dropped write to index 12
    wr_rule(3, 1'b1, 2'd2, 1'b0, 20'hFFFFF);
    wr_list(3, 32'h5A5A5A5A);
    wr_rule(12, 1'b1, 2'd3, 1'b0, 20'd0);
    look(mk_addr(20'd2000, 26'h00000C0), "R7");

    // R11: stall with a waiting request
    req_valid = 1'b1; req_addr = mk_addr(20'd700, 26'h0); cur_tag = "R11";
    tick();
    req_addr = mk_addr(20'd10, 26'h0010000);
    res_ready = 1'b0;
    repeat (3) tick();
    res_ready = 1'b1;
    tick();
    req_valid = 1'b0;
    repeat (2) tick();

    // ascending partition before the random phase
    for (int r = 0; r < 10; r++) begin
      wr_rule(r, 1'b1, 2'(r % 4), 1'(r % 2), 20'((r + 1) * 100));
      wr_list(r, $urandom);
    end

    // R10 + random mixture
    for (int c = 0; c < 4000; c++) begin
      if (!(req_valid && !acc_prev)) begin
        req_valid = ($urandom % 5) != 0;
        if (($urandom % 8) == 0)
          req_addr = mk_addr(20'($urandom_range(0, 2000)), 26'($urandom));
        else
          req_addr = mk_addr(m_lim[$urandom % 10] + 20'($urandom % 3) - 20'd1,
                             26'($urandom));
        cur_tag = (c % 2 == 0) ? "R4" : "R3";
      end
      res_ready = ($urandom % 4) != 0;
      cfg_we = ($urandom % 16) == 0;
      cfg_idx = 4'($urandom % 11);
      cfg_kind = $urandom % 2;
      if (cfg_kind)
        cfg_wdata = $urandom;
      else
        cfg_wdata = {8'h00, 20'($urandom_range(0, 1100)), 1'($urandom),
                     2'($urandom), 1'(($urandom % 4) != 0)};
      tick();
    end
    cfg_we = 1'b0;
    req_valid = 1'b0;
    res_ready = 1'b1;
    repeat (4) tick();
    chk(exp_q.size() == 0, "R10", "all results delivered", 32'(exp_q.size()), 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule